// File: doc/BRIEF.md
# DMA Channel Address Generator with Page Extension

This block sequences the transfer address and the transfer count of one DMA channel and turns them into a 32-bit physical bus address. A 16-bit current-address counter sits under an 8-bit page register and an 8-bit high-page register. A parameter picks the channel width. A byte channel places the counter on the low 16 address bits. A word channel shifts the counter up by one bit, forces address bit 0 low and does not use page bit 0.

Each accepted transfer strobe moves the address by one unit and lowers the count by one. The count is loaded as the number of transfers minus one. Terminal count is signalled when the count steps from zero to all ones. Software can read a residue in bytes at any time.

By default the counter wraps inside its 64 KB (byte) or 128 KB (word) window. Writing the high-page register, as the last step of setup, turns on extended mode. In extended mode a carry or a borrow runs through page and high-page as one wide step. Writing the page register again turns extended mode off.

Control is a two-state machine: S_MASKED (transfers ignored) and S_ACTIVE (transfers accepted). Transition T_ARM is an unmask write and moves S_MASKED to S_ACTIVE. T_DISARM is a mask write and moves S_ACTIVE to S_MASKED. T_FINISH is terminal count with auto-initialise clear and moves S_ACTIVE to S_MASKED. T_RELOAD is terminal count with auto-initialise set: it keeps S_ACTIVE and reloads the current address and count from their base copies.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the channel is masked, tc is low, all registers are zero and extended mode is off. The bus address therefore reads 0 and the residue reads 1 unit.
- R2: On a byte channel the bus address is {high-page, page, counter}. byte_en is 2'b01 when counter bit 0 is 0 and 2'b10 when it is 1.
- R3: On a word channel the bus address is {high-page, page[7:1], counter, 1'b0}. Page bit 0 has no effect on it, and byte_en is 2'b11.
- R4: With extended mode off, the counter wraps at 16 bits and the page and high-page values stay unchanged. A page write turns extended mode off.
- R5: A high-page write turns extended mode on. A step then moves the whole address field above bit 0 (word) or from bit 0 (byte) by one, with carry or borrow into page and high-page.
- R6: Each transfer strobe accepted in S_ACTIVE adds one to the counter, or subtracts one when mode bit 1 is set. A strobe in S_MASKED changes nothing.
- R7: The count register holds the number of transfers minus one and is lowered by each accepted strobe. tc is high for one cycle, in the cycle after the strobe that finds the count at zero, and the count then reads all ones.
- R8: residue equals (count + 1) mod 65536 for a byte channel, and twice that for a word channel. It reads 0 after the last transfer.
- R9: At terminal count with mode bit 0 (auto-initialise) clear, the channel goes to S_MASKED. With it set, the channel stays in S_ACTIVE and the current address and count reload from the values last written.
- R10: When a register write and an accepted strobe fall in the same cycle, the write wins for the register or state it targets. The strobe still updates the other registers, and tc still fires.
- R11: The write select codes are: 0 address (loads base and current), 1 count (loads base and current), 2 page, 3 high-page, 4 mode (bit 0 auto-initialise, bit 1 decrement), 5 unmask, 6 mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select (R11) |
| wr_data | input | CNT_W | Write data |
| xfer | input | 1 | Transfer strobe, one per completed transfer |
| bus_addr | output | CNT_W+2*PG_W | Physical bus address |
| byte_en | output | 2 | Active byte lanes on a 16-bit bus |
| tc | output | 1 | Terminal count pulse |
| masked | output | 1 | High in S_MASKED |
| residue | output | CNT_W+1 | Bytes still to be transferred |

## Verification
Two functions can collide in one cycle: the terminal-count step, which by itself would move the channel to S_MASKED, and a software write to the mask state or to the count. The bench provokes this by raising the transfer strobe and a write strobe on the same clock edge, first with an unmask write on the final transfer and then with a count write on an ordinary transfer. It judges the result at the ports. tc must pulse while masked stays low. The address must still step while the residue shows the newly written count rather than the decremented one.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
    typedef enum logic [2:0] {
        SEL_ADDR   = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_PAGE   = 3'd2,
        SEL_HIPAGE = 3'd3,
        SEL_MODE   = 3'd4,
        SEL_UNMASK = 3'd5,
        SEL_MASK   = 3'd6
    } wr_sel_e;

    typedef enum logic {
        S_MASKED = 1'b0,
        S_ACTIVE = 1'b1
    } chan_state_e;
endpackage

// File: rtl/dma_ag_addr.sv
module dma_ag_addr #(
    parameter int WORD_CH = 0,
    parameter int CNT_W   = 16,
    parameter int PG_W    = 8,
    localparam int BUS_W  = CNT_W + 2 * PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_addr,
    input  logic             ld_page,
    input  logic             ld_hipage,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    input  logic             dec,
    input  logic             reload,
    output logic [BUS_W-1:0] bus_addr,
    output logic [1:0]       byte_en
);
    localparam logic [CNT_W-1:0] ONE_C = 1;

    logic [CNT_W-1:0] base_q, cur_q, cur_wrap;
    logic [PG_W-1:0]  page_q, hipage_q, page_n, hipage_n;
    logic [CNT_W-1:0] cur_ext;
    logic             ext_q;

    assign cur_wrap = dec ? cur_q - ONE_C : cur_q + ONE_C;

    generate
        if (WORD_CH != 0) begin : g_word
            localparam int LW = CNT_W + 2 * PG_W - 1;
            localparam logic [LW-1:0] ONE_L = 1;
            logic [LW-1:0] lin, lin_n;
            assign lin      = {hipage_q, page_q[PG_W-1:1], cur_q};
            assign lin_n    = dec ? lin - ONE_L : lin + ONE_L;
            assign hipage_n = lin_n[LW-1 -: PG_W];
            assign page_n   = {lin_n[CNT_W +: PG_W-1], page_q[0]};
            assign cur_ext  = lin_n[CNT_W-1:0];
            assign bus_addr = {lin, 1'b0};
            assign byte_en  = 2'b11;
        end else begin : g_byte
            localparam int LW = CNT_W + 2 * PG_W;
            localparam logic [LW-1:0] ONE_L = 1;
            logic [LW-1:0] lin, lin_n;
            assign lin      = {hipage_q, page_q, cur_q};
            assign lin_n    = dec ? lin - ONE_L : lin + ONE_L;
            assign hipage_n = lin_n[LW-1 -: PG_W];
            assign page_n   = lin_n[CNT_W +: PG_W];
            assign cur_ext  = lin_n[CNT_W-1:0];
            assign bus_addr = lin;
            assign byte_en  = cur_q[0] ? 2'b10 : 2'b01;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cur_q    <= '0;
            page_q   <= '0;
            hipage_q <= '0;
            ext_q    <= 1'b0;
        end else begin
            if (ld_addr) begin
                base_q <= wdata;
                cur_q  <= wdata;
            end else if (reload) begin
                cur_q <= base_q;
            end else if (step) begin
                if (ext_q) begin
                    cur_q    <= cur_ext;
                    page_q   <= page_n;
                    hipage_q <= hipage_n;
                end else begin
                    cur_q <= cur_wrap;
                end
            end
            if (ld_page) begin
                page_q <= wdata[PG_W-1:0];
                ext_q  <= 1'b0;
            end
            if (ld_hipage) begin
                hipage_q <= wdata[PG_W-1:0];
                ext_q    <= 1'b1;
            end
        end
    end

    AST_PAGE_HOLD_NOEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_q && !ld_page && !ld_hipage) |=> ($stable(page_q) && $stable(hipage_q))); // R4
endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
    parameter int WORD_CH = 0,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    input  logic             reload,
    output logic             tc_hit,
    output logic [CNT_W:0]   residue
);
    localparam logic [CNT_W-1:0] ONE_C = 1;

    logic [CNT_W-1:0] base_q, cur_q, plus1;

    assign tc_hit = step && (cur_q == '0);
    assign plus1  = cur_q + ONE_C;

    generate
        if (WORD_CH != 0) begin : g_word
            assign residue = {plus1, 1'b0};
        end else begin : g_byte
            assign residue = {1'b0, plus1};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (ld_cnt) begin
            base_q <= wdata;
            cur_q  <= wdata;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step) begin
            cur_q <= cur_q - ONE_C;
        end
    end

    AST_CNT_WRAP_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur_q == '0 && !ld_cnt && !reload) |=> (cur_q == '1)); // R7
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int WORD_CH = 0,
    parameter int CNT_W   = 16,
    parameter int PG_W    = 8,
    localparam int BUS_W  = CNT_W + 2 * PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             xfer,
    output logic [BUS_W-1:0] bus_addr,
    output logic [1:0]       byte_en,
    output logic             tc,
    output logic             masked,
    output logic [CNT_W:0]   residue
);
    chan_state_e state_q, state_n;
    logic auto_q, dec_q, tc_q;
    logic step, tc_hit, reload;
    logic wr_unmask, wr_mask, wr_mode;

    assign wr_unmask = wr_en && (wr_sel == SEL_UNMASK);
    assign wr_mask   = wr_en && (wr_sel == SEL_MASK);
    assign wr_mode   = wr_en && (wr_sel == SEL_MODE);
    assign step      = xfer && (state_q == S_ACTIVE);
    assign reload    = tc_hit && auto_q;

    dma_ag_addr #(.WORD_CH(WORD_CH), .CNT_W(CNT_W), .PG_W(PG_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (wr_en && (wr_sel == SEL_ADDR)),
        .ld_page  (wr_en && (wr_sel == SEL_PAGE)),
        .ld_hipage(wr_en && (wr_sel == SEL_HIPAGE)),
        .wdata    (wr_data),
        .step     (step),
        .dec      (dec_q),
        .reload   (reload),
        .bus_addr (bus_addr),
        .byte_en  (byte_en)
    );

    dma_ag_count #(.WORD_CH(WORD_CH), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_cnt (wr_en && (wr_sel == SEL_COUNT)),
        .wdata  (wr_data),
        .step   (step),
        .reload (reload),
        .tc_hit (tc_hit),
        .residue(residue)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_MASKED: if (wr_unmask) state_n = S_ACTIVE;
            S_ACTIVE: begin
                if (wr_mask)                     state_n = S_MASKED;
                else if (wr_unmask)              state_n = S_ACTIVE;
                else if (tc_hit && !auto_q)      state_n = S_MASKED;
            end
            default: state_n = S_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_MASKED;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q   <= 1'b0;
            auto_q <= 1'b0;
            dec_q  <= 1'b0;
        end else begin
            tc_q <= tc_hit;
            if (wr_mode) begin
                auto_q <= wr_data[0];
                dec_q  <= wr_data[1];
            end
        end
    end

    assign tc     = tc_q;
    assign masked = (state_q == S_MASKED);

    AST_TC_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> $past(xfer)); // R7
    AST_MASK_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit && !auto_q && !wr_en) |=> masked); // R9
    AST_ACTIVE_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit && auto_q && !wr_en) |=> !masked); // R9
    AST_MASKED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !wr_en) |=> $stable(bus_addr)); // R6
endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en0 = 1'b0, wr_en1 = 1'b0, xfer0 = 1'b0, xfer1 = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] addr0, addr1;
    logic [1:0]  be0, be1;
    logic        tc0, tc1, mk0, mk1;
    logic [16:0] res0, res1;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_addr_gen #(.WORD_CH(0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en0), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer(xfer0), .bus_addr(addr0), .byte_en(be0), .tc(tc0), .masked(mk0), .residue(res0));

    dma_addr_gen #(.WORD_CH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en1), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer(xfer1), .bus_addr(addr1), .byte_en(be1), .tc(tc1), .masked(mk1), .residue(res1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int t, input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_sel = s; wr_data = d;
        if (t == 0) wr_en0 = 1'b1; else wr_en1 = 1'b1;
        @(negedge clk);
        wr_en0 = 1'b0; wr_en1 = 1'b0;
    endtask

    task automatic pulse(input int t);
        @(negedge clk);
        if (t == 0) xfer0 = 1'b1; else xfer1 = 1'b1;
        @(negedge clk);
        xfer0 = 1'b0; xfer1 = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 masked", {31'd0, mk0}, 32'd1);
        chk("R1 tc", {31'd0, tc0}, 32'd0);
        chk("R1 addr", addr0, 32'd0);
        chk("R1 residue", {15'd0, res0}, 32'd1);
    endtask

    task automatic t_byte_map;
        wr(0, 3'd2, 16'h0012); wr(0, 3'd0, 16'hFFFE); wr(0, 3'd1, 16'h0003); wr(0, 3'd4, 16'h0000);
        chk("R2 map", addr0, 32'h0012FFFE);
        chk("R2 be even", {30'd0, be0}, 32'd1);
        pulse(0);
        chk("R6 masked strobe ignored", addr0, 32'h0012FFFE);
        wr(0, 3'd5, 16'h0);
        pulse(0);
        chk("R6 step", addr0, 32'h0012FFFF);
        chk("R2 be odd", {30'd0, be0}, 32'd2);
        pulse(0);
        chk("R4 wrap in 64K", addr0, 32'h00120000);
        chk("R8 residue mid", {15'd0, res0}, 32'd2);
        pulse(0); pulse(0);
        chk("R7 tc", {31'd0, tc0}, 32'd1);
        chk("R9 finish masks", {31'd0, mk0}, 32'd1);
        chk("R8 residue end", {15'd0, res0}, 32'd0);
        pulse(0);
        chk("R6 ignored after finish", addr0, 32'h00120002);
        chk("R7 tc one cycle", {31'd0, tc0}, 32'd0);
    endtask

    task automatic t_ext;
        wr(0, 3'd2, 16'h0012); wr(0, 3'd0, 16'hFFFF); wr(0, 3'd1, 16'h0000); wr(0, 3'd3, 16'h0034);
        wr(0, 3'd5, 16'h0);
        chk("R5 hipage map", addr0, 32'h3412FFFF);
        pulse(0);
        chk("R5 carry into page", addr0, 32'h34130000);
        chk("R7 single transfer tc", {31'd0, tc0}, 32'd1);
        wr(0, 3'd2, 16'h0040); wr(0, 3'd0, 16'hFFFF); wr(0, 3'd1, 16'h0005); wr(0, 3'd5, 16'h0);
        pulse(0);
        chk("R4 page write ends extended", addr0, 32'h34400000);
        wr(0, 3'd6, 16'h0);
        chk("R11 mask write", {31'd0, mk0}, 32'd1);
    endtask

    task automatic t_autoinit;
        wr(0, 3'd4, 16'h0001); wr(0, 3'd2, 16'h0000); wr(0, 3'd0, 16'h0100); wr(0, 3'd1, 16'h0001);
        wr(0, 3'd5, 16'h0);
        pulse(0);
        chk("R6 auto step", addr0, 32'h34000101);
        pulse(0);
        chk("R9 auto tc", {31'd0, tc0}, 32'd1);
        chk("R9 auto stays active", {31'd0, mk0}, 32'd0);
        chk("R9 addr reload", addr0, 32'h34000100);
        chk("R9 count reload", {15'd0, res0}, 32'd2);
    endtask

    task automatic t_collide;
        wr(0, 3'd4, 16'h0000); wr(0, 3'd0, 16'h0200); wr(0, 3'd1, 16'h0000);
        @(negedge clk);
        xfer0 = 1'b1; wr_en0 = 1'b1; wr_sel = 3'd5; wr_data = 16'h0;
        @(negedge clk);
        xfer0 = 1'b0; wr_en0 = 1'b0;
        chk("R10 tc with unmask", {31'd0, tc0}, 32'd1);
        chk("R10 unmask wins", {31'd0, mk0}, 32'd0);
        chk("R10 addr stepped", addr0, 32'h34000201);
        @(negedge clk);
        xfer0 = 1'b1; wr_en0 = 1'b1; wr_sel = 3'd1; wr_data = 16'h0007;
        @(negedge clk);
        xfer0 = 1'b0; wr_en0 = 1'b0;
        chk("R10 count write wins", {15'd0, res0}, 32'd8);
        chk("R10 addr still steps", addr0, 32'h34000202);
        chk("R10 no tc", {31'd0, tc0}, 32'd0);
    endtask

    task automatic t_word;
        wr(1, 3'd2, 16'h0013); wr(1, 3'd0, 16'h8000); wr(1, 3'd1, 16'h0001); wr(1, 3'd4, 16'h0000);
        chk("R3 word map", addr1, 32'h00130000);
        chk("R3 word be", {30'd0, be1}, 32'd3);
        chk("R8 word residue", {15'd0, res1}, 32'd4);
        wr(1, 3'd2, 16'h0012);
        chk("R3 page bit0 ignored", addr1, 32'h00130000);
        wr(1, 3'd5, 16'h0);
        pulse(1);
        chk("R3 word step", addr1, 32'h00130002);
        chk("R8 word residue mid", {15'd0, res1}, 32'd2);
        pulse(1);
        chk("R7 word tc", {31'd0, tc1}, 32'd1);
        chk("R8 word residue end", {15'd0, res1}, 32'd0);
        wr(1, 3'd0, 16'hFFFF); wr(1, 3'd1, 16'h0003); wr(1, 3'd5, 16'h0);
        chk("R3 word top", addr1, 32'h0013FFFE);
        pulse(1);
        chk("R4 wrap in 128K", addr1, 32'h00120000);
        wr(1, 3'd6, 16'h0);
        wr(1, 3'd4, 16'h0002); wr(1, 3'd2, 16'h0013); wr(1, 3'd0, 16'h0000);
        wr(1, 3'd1, 16'h0000); wr(1, 3'd3, 16'h0001); wr(1, 3'd5, 16'h0);
        chk("R5 word hipage", addr1, 32'h01120000);
        pulse(1);
        chk("R5 word borrow", addr1, 32'h0111FFFE);
        chk("R9 word finish", {31'd0, mk1}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_map();
        t_ext();
        t_autoinit();
        t_collide();
        t_word();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule